// File: doc/BRIEF.md
# Paged Coefficient Register Bank with Atomic Four-Byte Commit

This block holds seven 32-bit signed coefficients behind a byte-wide host bus. Each coefficient spans four consecutive byte addresses. The lowest address carries the top byte. Address 0x00 is a page select register. The coefficients are visible only while the page register holds the coefficient page.

Host writes are collected in a staging register. A coefficient changes only when its least significant byte completes an ordered, uninterrupted sequence that starts at its most significant byte. The seven committed values are driven in parallel to the datapath.

There are two read paths. The host bus returns one byte per read. A serial-style read path returns a dummy byte first and then the four coefficient bytes, most significant first. Both read paths return committed values only.

Top module: `coef_regbank`

## Requirements
- R1: After reset, the page register reads 0x00. The coefficients at offsets 0x08, 0x1C and 0x48 (coef_flat slots 0, 3 and 4) hold 0x7FFFFFFF. The other four coefficients hold 0x00000000. Slots 0 to 6 map to offsets 0x08, 0x0C, 0x18, 0x1C, 0x48, 0x4C and 0x50, and slot k sits at coef_flat[32k+31:32k].
- R2: Address 0x00 is the page register on every page. A write stores wdata. A read returns the stored value on rdata one clock later.
- R3: On the coefficient page (COEF_PAGE, default 0x04), offset+0 of a coefficient holds bits [31:24], offset+1 holds [23:16], offset+2 holds [15:8] and offset+3 holds [7:0].
- R4: Writing the first three bytes in order leaves coef_flat unchanged. The write to offset+3 updates all 32 bits of that slot together, visible in the cycle after that write.
- R5: A sequence is discarded and the committed value is kept in three cases. These are: the first write is not offset+0, an address is skipped, or any other write comes between the bytes.
- R6: Reads issued while a sequence is being staged return the committed value, not the staged bytes. Reads do not break a sequence.
- R7: A read of offset+0 latches the whole committed coefficient. Later reads of offset+1..+3 of the same coefficient return bytes of that latched word, even if a commit happened after the latch.
- R8: Reads of unmapped offsets, or of coefficient offsets while the page register differs from COEF_PAGE, return 0x00. Writes to them change no coefficient.
- R9: A pulse on spi_start with addr at a coefficient's offset+0 puts DUMMY_BYTE (default 0xA5) on spi_byte in the next cycle. Each following spi_shift cycle then presents the next coefficient byte, most significant first, and 0x00 after the fourth.
- R10: rdata changes only in the cycle after a cycle with rd_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 8 | Byte address for host and serial accesses |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Host read data, registered |
| spi_start | input | 1 | Start a serial coefficient read at addr |
| spi_shift | input | 1 | Advance the serial read by one byte |
| spi_byte | output | 8 | Serial read byte, registered |
| coef_flat | output | 224 | Seven committed coefficients, slot k at [32k+31:32k] |

## Verification
Staging state cannot be seen directly. A fault in the sequence tracking shows up as a coefficient that changes early, changes after a broken sequence, or fails to change after a complete one. Each of these appears on coef_flat in the cycle after the offending write. A fault in the read latch shows as a mix of old and new bytes in the reads that follow an MSB read. A dropped or misplaced dummy byte shifts every serial byte by one position, and this is visible from the first spi_byte after spi_start.

// File: rtl/coef_regbank.sv
module coef_regbank #(
  parameter logic [7:0] COEF_PAGE  = 8'h04,
  parameter logic [7:0] DUMMY_BYTE = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic         spi_start,
  input  logic         spi_shift,
  output logic [7:0]   spi_byte,
  output logic [223:0] coef_flat
);
  localparam int NCOEF = 7;

  function automatic logic [3:0] slot_of(input logic [5:0] w);
    case (w)
      6'd2:    slot_of = 4'd0;
      6'd3:    slot_of = 4'd1;
      6'd6:    slot_of = 4'd2;
      6'd7:    slot_of = 4'd3;
      6'd18:   slot_of = 4'd4;
      6'd19:   slot_of = 4'd5;
      6'd20:   slot_of = 4'd6;
      default: slot_of = 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    rst_val = (i == 0 || i == 3 || i == 4) ? 32'h7FFF_FFFF : 32'h0;
  endfunction

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] k);
    case (k)
      2'd0:    pick = w[31:24];
      2'd1:    pick = w[23:16];
      2'd2:    pick = w[15:8];
      default: pick = w[7:0];
    endcase
  endfunction

  logic [7:0]  page_q;
  logic [31:0] coef_q [NCOEF];
  logic [23:0] stg_q;
  logic [2:0]  stg_idx;
  logic [1:0]  stg_pos;
  logic        stg_act;
  logic [31:0] lat_q;
  logic [2:0]  lat_idx;
  logic        lat_vld;
  logic [7:0]  rdata_q;
  logic [31:0] spi_word;
  logic [2:0]  spi_cnt;
  logic [7:0]  spi_q;

  logic [3:0]  map;
  logic        hit;
  logic [2:0]  cidx;
  logic [1:0]  bsel;
  logic [31:0] live;
  logic [31:0] rd_word;

  assign map  = slot_of(addr[7:2]);
  assign hit  = (page_q == COEF_PAGE) && !map[3];
  assign cidx = map[2:0];
  assign bsel = addr[1:0];
  assign live = hit ? coef_q[cidx] : 32'h0;
  assign rd_word = (bsel != 2'd0 && lat_vld && lat_idx == cidx) ? lat_q : live;

  assign rdata    = rdata_q;
  assign spi_byte = spi_q;

  for (genvar g = 0; g < NCOEF; g++) begin : g_out
    assign coef_flat[g*32 +: 32] = coef_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= 8'h00;
      stg_q   <= '0;
      stg_idx <= '0;
      stg_pos <= '0;
      stg_act <= 1'b0;
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= rst_val(i);
    end else if (wr_en) begin
      if (addr == 8'h00) page_q <= wdata;
      if (hit && bsel == 2'd0) begin
        stg_act        <= 1'b1;
        stg_idx        <= cidx;
        stg_pos        <= 2'd1;
        stg_q[23:16]   <= wdata;
      end else if (hit && stg_act && cidx == stg_idx && bsel == stg_pos) begin
        case (bsel)
          2'd1: stg_q[15:8] <= wdata;
          2'd2: stg_q[7:0]  <= wdata;
          default: ;
        endcase
        if (bsel == 2'd3) begin
          coef_q[cidx] <= {stg_q, wdata};
          stg_act      <= 1'b0;
        end else begin
          stg_pos <= stg_pos + 2'd1;
        end
      end else begin
        stg_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
      lat_q   <= '0;
      lat_idx <= '0;
      lat_vld <= 1'b0;
    end else if (rd_en) begin
      if (addr == 8'h00)      rdata_q <= page_q;
      else if (hit)           rdata_q <= pick(rd_word, bsel);
      else                    rdata_q <= 8'h00;
      if (hit && bsel == 2'd0) begin
        lat_q   <= live;
        lat_idx <= cidx;
        lat_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_word <= '0;
      spi_cnt  <= '0;
      spi_q    <= 8'h00;
    end else if (spi_start) begin
      spi_word <= (hit && bsel == 2'd0) ? live : 32'h0;
      spi_cnt  <= 3'd1;
      spi_q    <= DUMMY_BYTE;
    end else if (spi_shift && spi_cnt != 3'd0) begin
      spi_q <= (spi_cnt <= 3'd4) ? pick(spi_word, 2'(spi_cnt - 3'd1)) : 8'h00;
      if (spi_cnt != 3'd5) spi_cnt <= spi_cnt + 3'd1;
    end
  end
endmodule

// File: rtl/coef_regbank_chk.sv
module coef_regbank_chk #(
  parameter logic [7:0] COEF_PAGE  = 8'h04,
  parameter logic [7:0] DUMMY_BYTE = 8'hA5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [7:0]   addr,
  input logic         spi_start,
  input logic [7:0]   spi_byte,
  input logic [7:0]   rdata,
  input logic [223:0] coef_flat,
  input logic [7:0]   page_q
);
  AST_COMMIT_ON_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_flat != $past(coef_flat)) |-> $past(wr_en && addr[1:0] == 2'd3 && page_q == COEF_PAGE)); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata)); // R10

  AST_SPI_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_start && rst_n) |-> (spi_byte == DUMMY_BYTE)); // R9

  AST_OFF_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && page_q != COEF_PAGE) |-> $stable(coef_flat)); // R8

  AST_PAGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == 8'h00 && rst_n) |-> (rdata == $past(page_q))); // R2
endmodule

bind coef_regbank coef_regbank_chk #(.COEF_PAGE(COEF_PAGE), .DUMMY_BYTE(DUMMY_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .spi_start(spi_start), .spi_byte(spi_byte), .rdata(rdata),
  .coef_flat(coef_flat), .page_q(page_q)
);

// File: tb/coef_regbank_test.sv
`timescale 1ns/1ps
module coef_regbank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, spi_start = 1'b0, spi_shift = 1'b0;
  logic [7:0]   addr = 8'h00, wdata = 8'h00;
  logic [7:0]   rdata, spi_byte;
  logic [223:0] coef_flat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend = 1'b0;

  always #10 clk = ~clk;

  coef_regbank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .spi_start(spi_start), .spi_shift(spi_shift), .spi_byte(spi_byte),
    .coef_flat(coef_flat)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_coef(input string tag, input int slot, input logic [31:0] exp);
    checks++;
    if (coef_flat[slot*32 +: 32] !== exp) begin
      errors++;
      $display("FAIL %s: slot %0d got %08h expected %08h", tag, slot, coef_flat[slot*32 +: 32], exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] w);
    wr(a, w[31:24]); wr(a + 8'd1, w[23:16]); wr(a + 8'd2, w[15:8]); wr(a + 8'd3, w[7:0]);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_word(input logic [7:0] a, input logic [31:0] w, input string tag);
    rd(a, w[31:24], tag); rd(a + 8'd1, w[23:16], tag); rd(a + 8'd2, w[15:8], tag); rd(a + 8'd3, w[7:0], tag);
  endtask

  task automatic spi_read(input logic [7:0] a, input logic [31:0] w, input string tag);
    @(negedge clk);
    spi_start = 1'b1; addr = a;
    @(negedge clk);
    spi_start = 1'b0;
    #1 check8({tag, " dummy"}, spi_byte, 8'hA5);
    for (int i = 0; i < 5; i++) begin
      spi_shift = 1'b1;
      @(negedge clk);
      #1 check8(tag, spi_byte, (i < 4) ? w[31 - 8*i -: 8] : 8'h00);
    end
    spi_shift = 1'b0;
  endtask

  always @(posedge clk) pend <= rd_en;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (pend) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: unexpected read result got %02h expected none", rdata);
        end else begin
          check8(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_coef("R1 reset", 0, 32'h7FFF_FFFF);
    check_coef("R1 reset", 1, 32'h0);
    check_coef("R1 reset", 2, 32'h0);
    check_coef("R1 reset", 3, 32'h7FFF_FFFF);
    check_coef("R1 reset", 4, 32'h7FFF_FFFF);
    check_coef("R1 reset", 5, 32'h0);
    check_coef("R1 reset", 6, 32'h0);
    check8("R1 spi idle", spi_byte, 8'h00);
    rd(8'h00, 8'h00, "R1 page reset");
    rd(8'h08, 8'h00, "R8 wrong page");

    wr(8'h00, 8'h04);
    rd(8'h00, 8'h04, "R2 page readback");
    rd_word(8'h08, 32'h7FFF_FFFF, "R3 reset bytes");
    rd_word(8'h48, 32'h7FFF_FFFF, "R3 reset bytes");

    wr(8'h0C, 8'h11); wr(8'h0D, 8'h22); wr(8'h0E, 8'h33);
    #1 check_coef("R4 partial", 1, 32'h0);
    rd_word(8'h0C, 32'h0, "R6 staged hidden");
    wr(8'h0F, 8'h44);
    #1 check_coef("R4 commit", 1, 32'h1122_3344);
    rd_word(8'h0C, 32'h1122_3344, "R3 order");

    wr(8'h19, 8'hA1); wr(8'h1A, 8'hA2); wr(8'h1B, 8'hA3);
    #1 check_coef("R5 no msb", 2, 32'h0);
    wr(8'h18, 8'hB0); wr(8'h19, 8'hB1); wr(8'h1B, 8'hB3);
    #1 check_coef("R5 skip", 2, 32'h0);
    wr(8'h50, 8'hC0); wr(8'h51, 8'hC1); wr(8'h10, 8'h99); wr(8'h52, 8'hC2); wr(8'h53, 8'hC3);
    #1 check_coef("R5 interrupt", 6, 32'h0);
    wr_word(8'h50, 32'hDEAD_BEEF);
    #1 check_coef("R4 commit", 6, 32'hDEAD_BEEF);

    rd(8'h0C, 8'h11, "R7 latch");
    wr_word(8'h0C, 32'h5566_7788);
    #1 check_coef("R4 commit", 1, 32'h5566_7788);
    rd(8'h0D, 8'h22, "R7 latched"); rd(8'h0E, 8'h33, "R7 latched"); rd(8'h0F, 8'h44, "R7 latched");
    rd_word(8'h0C, 32'h5566_7788, "R7 relatch");

    wr_word(8'h10, 32'h0102_0304);
    rd_word(8'h10, 32'h0, "R8 unmapped");
    rd(8'h47, 8'h00, "R8 unmapped");
    wr(8'h00, 8'h01);
    wr_word(8'h08, 32'h0102_0304);
    #1 check_coef("R8 off page", 0, 32'h7FFF_FFFF);
    rd(8'h08, 8'h00, "R8 off page read");
    rd(8'h00, 8'h01, "R2 page readback");
    wr(8'h00, 8'h04);

    spi_read(8'h1C, 32'h7FFF_FFFF, "R9 spi reset");
    spi_read(8'h0C, 32'h5566_7788, "R9 spi commit");
    spi_read(8'h50, 32'hDEAD_BEEF, "R9 spi");

    rd(8'h51, 8'hAD, "R10 setup");
    repeat (2) @(negedge clk);
    #1 held = rdata;
    wr(8'h00, 8'h04);
    wr_word(8'h4C, 32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    #3 check8("R10 hold", rdata, held);
    check_coef("R4 commit", 5, 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending reads got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule